// File: doc/BRIEF.md
# Shadowed Multi-Channel PWM Generator

This block drives a set of independent pulse-width-modulated outputs, four by default, from a single clock. Each channel counts input clock cycles. Its output is high while the count is below the duty value, and the count wraps after the period value. Software programs the block through a plain 32-bit word-addressed register bus made of write enable, read enable, byte address, write data and registered read data.

Writes to a channel's period, duty and phase registers go to shadow storage only. A single commit command in the control register copies every channel's shadow values into the running set at one clock edge. The same command restarts all channel counters, so channels with harmonic periods stay phase-aligned. A core-reset bit in the control register holds every output low. The bit is set out of reset, so software must clear it before any output toggles. Fixed identification registers and a scratch register let software confirm that it is talking to the right block.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After rst_ni is released, every pwm_o bit is 0, the control register reads 0x1 and every channel register reads 0.
- R2: These registers are read-only. Word 0x0C always returns 0x601A3471, even after a write to it. Word 0x00 returns 0x00020000 (major version 2 in bits 23:16). Word 0x04 returns the ID_VAL parameter. Word 0x14 returns NUM_CH. Read data appears on rdata_o in the cycle after rd_en_i is sampled and is held until the next read.
- R3: Word 0x08 is a plain read/write scratch register.
- R4: Control bit 0 (word 0x10) is an active-high core reset and takes wdata_i[0] on every control write. While it is 1, all outputs are 0 and all counters are held at 0. After it is cleared, counters run from 0.
- R5: The shadow registers sit at these addresses: period at 0x40+4·ch, duty at 0x80+4·ch, phase at 0xC0+4·ch. Each reads back the last value written to it. A shadow write has no effect on pwm_o until a commit.
- R6: A control write with bit 1 set copies the shadows of all channels into the running set at that edge and restarts every counter in the same cycle. Bit 1 always reads as 0.
- R7: A running channel with period P and duty D counts 0 to P-1 and then wraps. Its output is high exactly while the count is below D.
- R8: A channel whose running period is 0 holds its output at 0.
- R9: A duty greater than or equal to a nonzero period gives an output that stays high.
- R10: At a commit, a channel's counter starts at its phase value, or at 0 if the phase is not below the period.
- R11: Reads of unmapped words, of channel indices at or above NUM_CH, or of addresses with nonzero bits 1:0 return 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; periods and duties are counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
The bound checker watches the following on every cycle:
- each counter stays below its running period;
- the running set changes only on a commit;
- a commit restarts each counter at its clamped phase;
- disabled channels and channels in core reset stay low;
- an oversized duty keeps the output high;
- reads return the fixed identification word and a zero commit bit.

Only the bench scenarios can show the rest:
- the full waveform shape;
- that shadow writes leave a running channel untouched until the next commit;
- that several channels line up after a commit;
- that counters count from 0 after the core reset is released;
- how unmapped and misaligned accesses behave.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;
  localparam int MAX_CH = 1 << IDX_W;

  localparam logic [REG_W-1:0] MAGIC_WORD   = 32'h601A_3471;
  localparam logic [REG_W-1:0] VERSION_WORD = 32'h0002_0000;

  // word index inside the global bank
  localparam logic [IDX_W-1:0] W_VERSION = 4'd0;
  localparam logic [IDX_W-1:0] W_IDENT   = 4'd1;
  localparam logic [IDX_W-1:0] W_SCRATCH = 4'd2;
  localparam logic [IDX_W-1:0] W_MAGIC   = 4'd3;
  localparam logic [IDX_W-1:0] W_CTRL    = 4'd4;
  localparam logic [IDX_W-1:0] W_NCH     = 4'd5;

  localparam int CTRL_RST_BIT    = 0;
  localparam int CTRL_COMMIT_BIT = 1;

  typedef enum logic [1:0] {
    BANK_GLOBAL = 2'b00,
    BANK_PERIOD = 2'b01,
    BANK_DUTY   = 2'b10,
    BANK_PHASE  = 2'b11
  } bank_e;

  typedef struct packed {
    logic [REG_W-1:0] per;
    logic [REG_W-1:0] duty;
    logic [REG_W-1:0] phase;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int               NUM_CH = 4,
  parameter logic [REG_W-1:0] ID_VAL = 32'h5057_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              core_rst_o,
  output logic              commit_o,
  output ch_cfg_t           shadow_o [NUM_CH]
);

  bank_e            bank;
  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             ch_hit;
  logic             glb_wr;
  logic [REG_W-1:0] scratch_q;
  logic             core_rst_q;
  logic [REG_W-1:0] rd_word;
  ch_cfg_t          rd_ch;

  assign bank    = bank_e'(addr_i[7:6]);
  assign idx     = addr_i[5:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    ch_hit = 1'b0;
    rd_ch  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (idx == IDX_W'(c)) begin
        ch_hit = 1'b1;
        rd_ch  = shadow_o[c];
      end
    end
  end

  assign glb_wr   = wr_en_i && aligned && (bank == BANK_GLOBAL);
  assign commit_o = glb_wr && (idx == W_CTRL) && wdata_i[CTRL_COMMIT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q  <= '0;
      core_rst_q <= 1'b1;
    end else if (glb_wr) begin
      if (idx == W_SCRATCH) scratch_q  <= wdata_i;
      if (idx == W_CTRL)    core_rst_q <= wdata_i[CTRL_RST_BIT];
    end
  end

  assign core_rst_o = core_rst_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_shadow
    logic sel;
    assign sel = wr_en_i && aligned && (idx == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_o[g] <= '0;
      end else if (sel) begin
        case (bank)
          BANK_PERIOD: shadow_o[g].per   <= wdata_i;
          BANK_DUTY:   shadow_o[g].duty  <= wdata_i;
          BANK_PHASE:  shadow_o[g].phase <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      case (bank)
        BANK_GLOBAL: begin
          case (idx)
            W_VERSION: rd_word = VERSION_WORD;
            W_IDENT:   rd_word = ID_VAL;
            W_SCRATCH: rd_word = scratch_q;
            W_MAGIC:   rd_word = MAGIC_WORD;
            W_CTRL:    rd_word = {{(REG_W-1){1'b0}}, core_rst_q};
            W_NCH:     rd_word = REG_W'(NUM_CH);
            default:   rd_word = '0;
          endcase
        end
        BANK_PERIOD: if (ch_hit) rd_word = rd_ch.per;
        BANK_DUTY:   if (ch_hit) rd_word = rd_ch.duty;
        BANK_PHASE:  if (ch_hit) rd_word = rd_ch.phase;
        default:     rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_word;
  end

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_rst_i,
  input  logic             commit_i,
  input  ch_cfg_t          shadow_i,
  output ch_cfg_t          act_o,
  output logic [REG_W-1:0] cnt_o,
  output logic             pwm_o
);

  ch_cfg_t          act_q;
  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] start;
  logic             running;
  logic             wrap;

  // phase at or beyond the period restarts at zero
  assign start   = (shadow_i.phase < shadow_i.per) ? shadow_i.phase : '0;
  assign running = (act_q.per != '0) && !core_rst_i;
  assign wrap    = (cnt_q >= act_q.per - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (commit_i) begin
      act_q <= shadow_i;
      cnt_q <= start;
    end else if (!running) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;
  assign cnt_o = cnt_q;
  assign pwm_o = running && (cnt_q < act_q.duty);

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int               NUM_CH = 4,
  parameter logic [REG_W-1:0] ID_VAL = 32'h5057_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);

  logic             core_rst;
  logic             commit;
  ch_cfg_t          shadow [NUM_CH];
  ch_cfg_t          act    [NUM_CH];
  logic [REG_W-1:0] cnt    [NUM_CH];

  pwm_shadow_regs #(
    .NUM_CH (NUM_CH),
    .ID_VAL (ID_VAL)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .core_rst_o (core_rst),
    .commit_o   (commit),
    .shadow_o   (shadow)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_shadow_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .core_rst_i (core_rst),
      .commit_i   (commit),
      .shadow_i   (shadow[g]),
      .act_o      (act[g]),
      .cnt_o      (cnt[g]),
      .pwm_o      (pwm_o[g])
    );
  end

endmodule

// File: rtl/pwm_shadow_gen_chk.sv
module pwm_shadow_gen_chk
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [NUM_CH-1:0] pwm_o,
  input logic              core_rst,
  input logic              commit,
  input ch_cfg_t           act [NUM_CH],
  input logic [REG_W-1:0]  cnt [NUM_CH]
);

  AST_MAGIC_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == 8'h0C |=> rdata_o == MAGIC_WORD); // R2

  AST_COMMIT_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == 8'h10 |=> rdata_o[CTRL_COMMIT_BIT] == 1'b0); // R6

  AST_CORE_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst |-> pwm_o == '0); // R4

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_ACTIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit |=> $stable(act[g])); // R5

    AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act[g].per == '0 |-> !pwm_o[g]); // R8

    AST_FULL_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !core_rst && act[g].per != '0 && act[g].duty >= act[g].per |-> pwm_o[g]); // R9

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act[g].per != '0 |-> cnt[g] < act[g].per); // R7

    AST_COMMIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit |=> cnt[g] == ((act[g].phase < act[g].per) ? act[g].phase : '0)); // R10
  end

endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .pwm_o    (pwm_o),
  .core_rst (core_rst),
  .commit   (commit),
  .act      (act),
  .cnt      (cnt)
);

// File: tb/pwm_shadow_gen_bench.sv
`timescale 1ns/1ps
module pwm_shadow_gen_bench;
  localparam int          NCH   = 4;
  localparam logic [31:0] IDV   = 32'hC0DE_0042;
  localparam logic [7:0]  A_CTL = 8'h10;

  // {period, duty, phase, expected output right after commit}
  localparam int VEC [10][4] = '{
    '{5, 2, 0, 1}, '{8, 3, 0, 1}, '{6, 6, 0, 1}, '{4, 9, 0, 1}, '{7, 3, 4, 0},
    '{5, 2, 9, 1}, '{0, 3, 0, 0}, '{1, 0, 0, 0}, '{3, 1, 2, 0}, '{7, 3, 2, 1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NCH-1:0] pwm_o;

  int checks = 0;
  int fails  = 0;
  int bp [NCH];
  int bd [NCH];
  int bs [NCH];
  logic [31:0] rv;

  always #2 clk_i = ~clk_i;

  pwm_shadow_gen #(.NUM_CH(NCH), .ID_VAL(IDV)) u_pwm_shadow_gen (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o, .pwm_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // callers are positioned at a falling edge; each access takes one cycle
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic program_ch(int ch, int p, int d, int ph);
    wr(8'(8'h40 + 4*ch), 32'(p));
    wr(8'(8'h80 + 4*ch), 32'(d));
    wr(8'(8'hC0 + 4*ch), 32'(ph));
    bp[ch] = p; bd[ch] = d;
    bs[ch] = (ph < p) ? ph : 0;
  endtask

  function automatic logic [NCH-1:0] exp_vec(int j);
    logic [NCH-1:0] v = '0;
    for (int c = 0; c < NCH; c++)
      if (bp[c] != 0) v[c] = ((bs[c] + j) % bp[c]) < bd[c];
    return v;
  endfunction

  task automatic cmp_cycles(string req, int n, int j0);
    for (int k = 0; k < n; k++) begin
      chk(req, 32'(pwm_o), 32'(exp_vec(j0 + k)));
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin bp[c] = 0; bd[c] = 0; bs[c] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 pwm", 32'(pwm_o), 32'h0);
    rd(A_CTL, rv);  chk("R1 ctrl", rv, 32'h1);
    rd(8'h80, rv);  chk("R1 duty0", rv, 32'h0);
    rd(8'hCC, rv);  chk("R1 phase3", rv, 32'h0);

    // R2 identification
    rd(8'h0C, rv);  chk("R2 magic", rv, 32'h601A_3471);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, rv);  chk("R2 magic ro", rv, 32'h601A_3471);
    rd(8'h00, rv);  chk("R2 version", rv, 32'h0002_0000);
    rd(8'h04, rv);  chk("R2 id", rv, IDV);
    rd(8'h14, rv);  chk("R2 nch", rv, 32'(NCH));
    @(negedge clk_i);
    chk("R2 hold", rdata_o, 32'(NCH));

    // R3 scratch
    wr(8'h08, 32'hA5A5_5A5A);
    rd(8'h08, rv);  chk("R3 scratch", rv, 32'hA5A5_5A5A);
    wr(8'h08, 32'h0);
    rd(8'h08, rv);  chk("R3 scratch clr", rv, 32'h0);

    // R4 commit while core reset held: outputs stay low
    program_ch(0, 4, 2, 0);
    wr(A_CTL, 32'h3);
    for (int k = 0; k < 6; k++) begin
      chk("R4 held low", 32'(pwm_o), 32'h0);
      @(negedge clk_i);
    end
    rd(A_CTL, rv);  chk("R6 commit reads 0", rv, 32'h1);

    // table walk: R7 R8 R9 R10 on channel 0
    for (int i = 0; i < 10; i++) begin
      program_ch(0, VEC[i][0], VEC[i][1], VEC[i][2]);
      wr(A_CTL, 32'h2);
      chk($sformatf("R10 vec%0d first", i), 32'(pwm_o[0]), 32'(VEC[i][3]));
      cmp_cycles($sformatf("R7 vec%0d wave", i), 2 * VEC[i][0] + 6, 0);
    end

    // R5 shadow writes do not disturb a running channel
    program_ch(0, 5, 2, 0);
    wr(A_CTL, 32'h2);
    wr(8'h40, 32'd3);
    wr(8'h80, 32'd3);
    cmp_cycles("R5 shadow no effect", 10, 2);
    rd(8'h40, rv);  chk("R5 readback", rv, 32'd3);
    bp[0] = 3; bd[0] = 3; bs[0] = 0;
    wr(A_CTL, 32'h2);
    cmp_cycles("R9 after commit", 6, 0);

    // R6 all channels committed and aligned together
    program_ch(0, 4, 1, 0);
    program_ch(1, 8, 4, 0);
    program_ch(2, 6, 2, 3);
    program_ch(3, 2, 1, 0);
    wr(A_CTL, 32'h2);
    cmp_cycles("R6 multi", 16, 0);
    repeat (3) @(negedge clk_i);
    wr(A_CTL, 32'h2);
    cmp_cycles("R6 restart", 8, 0);

    // R4 core reset then release: counters resume from 0
    wr(A_CTL, 32'h1);
    for (int k = 0; k < 5; k++) begin
      chk("R4 all low", 32'(pwm_o), 32'h0);
      @(negedge clk_i);
    end
    for (int c = 0; c < NCH; c++) bs[c] = 0;
    wr(A_CTL, 32'h0);
    cmp_cycles("R4 resume", 12, 0);

    // R11 unmapped and misaligned
    rd(8'h18, rv);  chk("R11 gap", rv, 32'h0);
    rd(8'h3C, rv);  chk("R11 gap2", rv, 32'h0);
    wr(8'h50, 32'h1234);
    rd(8'h50, rv);  chk("R11 ch oob", rv, 32'h0);
    rd(8'h41, rv);  chk("R11 misaligned rd", rv, 32'h0);
    wr(8'h42, 32'd99);
    rd(8'h40, rv);  chk("R11 misaligned wr", rv, 32'd4);
    rd(8'h08, rv);  chk("R11 scratch intact", rv, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule